// File: doc/BRIEF.md
# Segmented DAC Digital Front End

This block is the digital input path of a 10-bit current-steering converter whose upper section is built from equal unit cells and whose lower section is a binary-weighted ladder. Each cycle it takes a 10-bit data word and a polarity control. When the polarity control is high, all ten bits are inverted. The resulting code is then split into a 4-bit segment and a 6-bit binary part. The segment is decoded into 15 unary cell enables. The binary part passes through as ladder controls.

Every cell and ladder control comes from one output register, so all of them change on the same rising edge. This keeps unequal path delays from showing up as glitches in the analog section. A derived level output reports the output magnitude in LSB units, built from the registered controls. Integration and checking logic can compare it with the code that was driven.

Top module: `seg_dac_front`

## Requirements
- R1: The data word is 10 bits wide. Bits 9..6 form the segment that drives the unary cells, and bits 5..0 form the binary ladder part.
- R2: With `invert_i` = 1, all ten data bits are inverted before the split (effective code = 1023 − code). With `invert_i` = 0, the code is used unchanged. `invert_i` is sampled in the same cycle as the data it applies to.
- R3: `therm_o` has 15 lines. A segment value k turns on exactly lines 0..k−1, so the active lines are always a contiguous run of ones starting at bit 0.
- R4: `bin_o` equals bits 5..0 of the effective code, as a plain binary value.
- R5: The latency from `data_i`/`invert_i` to `therm_o`/`bin_o` is exactly one rising edge. All controls update on that same edge, and there is no bypass path.
- R6: While `rst_ni` is low, all controls are off: `therm_o` = 0, `bin_o` = 0, `level_o` = 0. Data presented during reset has no effect.
- R7: `level_o` = 64 × (number of active `therm_o` lines) + `bin_o`, and this equals the effective code that was registered.
- R8: End points and mid-scale. With `invert_i` = 0, codes 0, 512 and 1023 give levels 0, 512 and 1023. With `invert_i` = 1, the same codes give levels 1023, 511 and 0.
- R9: Between codes 0x01F and 0x3E0 (with `invert_i` = 0), 21 controls toggle (all 15 unary lines and all 6 binary bits). Across the mid-scale step 0x1FF to 0x200, only 7 toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the controls load on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; clears all controls |
| data_i | input | 10 | Input code, bit 9 is the MSB |
| invert_i | input | 1 | 1 = invert all data bits before encoding |
| therm_o | output | 15 | Registered unary cell enables, line 0 first |
| bin_o | output | 6 | Registered binary ladder controls |
| level_o | output | 10 | Modelled output magnitude in LSB units |

## Verification
The clocked properties assume that `data_i` and `invert_i` are stable and known around each rising edge. They also assume that reset is released between edges, so the cycle that each `$past` refers to was a loaded cycle. The stimulus drives every input on the falling edge and releases reset on a falling edge. It sweeps all 1024 codes under both polarities, then toggles the polarity on every cycle, so each sampled pair is well defined. The outputs are compared on the falling edge that follows the loading edge.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;
  parameter int unsigned DATA_W = 10;
  parameter int unsigned SEG_W  = 4;
  localparam int unsigned BIN_W   = DATA_W - SEG_W;
  localparam int unsigned THERM_W = (1 << SEG_W) - 1;
endpackage

// File: rtl/seg_dac_polarity.sv
module seg_dac_polarity #(
  parameter int unsigned W = seg_dac_pkg::DATA_W
) (
  input  logic [W-1:0] data_i,
  input  logic         invert_i,
  output logic [W-1:0] code_o
);
  assign code_o = invert_i ? ~data_i : data_i;
endmodule

// File: rtl/seg_dac_therm_enc.sv
module seg_dac_therm_enc #(
  parameter int unsigned SEG_W   = seg_dac_pkg::SEG_W,
  parameter int unsigned THERM_W = (1 << SEG_W) - 1
) (
  input  logic [SEG_W-1:0]   seg_i,
  output logic [THERM_W-1:0] therm_o
);
  // line j is on when the segment value exceeds j
  for (genvar j = 0; j < THERM_W; j++) begin : g_line
    assign therm_o[j] = (32'(seg_i) > j);
  end
endmodule

// File: rtl/seg_dac_switch_reg.sv
module seg_dac_switch_reg #(
  parameter int unsigned THERM_W = seg_dac_pkg::THERM_W,
  parameter int unsigned BIN_W   = seg_dac_pkg::BIN_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [THERM_W-1:0] therm_d_i,
  input  logic [BIN_W-1:0]   bin_d_i,
  output logic [THERM_W-1:0] therm_q_o,
  output logic [BIN_W-1:0]   bin_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      therm_q_o <= '0;
      bin_q_o   <= '0;
    end else begin
      therm_q_o <= therm_d_i;
      bin_q_o   <= bin_d_i;
    end
  end
endmodule

// File: rtl/seg_dac_level.sv
module seg_dac_level #(
  parameter int unsigned SEG_W   = seg_dac_pkg::SEG_W,
  parameter int unsigned BIN_W   = seg_dac_pkg::BIN_W,
  parameter int unsigned THERM_W = (1 << SEG_W) - 1
) (
  input  logic [THERM_W-1:0]     therm_i,
  input  logic [BIN_W-1:0]       bin_i,
  output logic [SEG_W+BIN_W-1:0] level_o
);
  logic [SEG_W-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int j = 0; j < THERM_W; j++) cnt = cnt + SEG_W'(therm_i[j]);
  end

  // count * 2^BIN_W + binary part
  assign level_o = {cnt, bin_i};
endmodule

// File: rtl/seg_dac_front.sv
module seg_dac_front #(
  parameter int unsigned DATA_W = seg_dac_pkg::DATA_W,
  parameter int unsigned SEG_W  = seg_dac_pkg::SEG_W,
  localparam int unsigned BIN_W   = DATA_W - SEG_W,
  localparam int unsigned THERM_W = (1 << SEG_W) - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DATA_W-1:0]  data_i,
  input  logic               invert_i,
  output logic [THERM_W-1:0] therm_o,
  output logic [BIN_W-1:0]   bin_o,
  output logic [DATA_W-1:0]  level_o
);
  logic [DATA_W-1:0]  eff_code;
  logic [THERM_W-1:0] therm_d;

  seg_dac_polarity #(.W(DATA_W)) i_polarity (
    .data_i   (data_i),
    .invert_i (invert_i),
    .code_o   (eff_code)
  );

  seg_dac_therm_enc #(.SEG_W(SEG_W), .THERM_W(THERM_W)) i_therm_enc (
    .seg_i   (eff_code[DATA_W-1:BIN_W]),
    .therm_o (therm_d)
  );

  seg_dac_switch_reg #(.THERM_W(THERM_W), .BIN_W(BIN_W)) i_switch_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .therm_d_i (therm_d),
    .bin_d_i   (eff_code[BIN_W-1:0]),
    .therm_q_o (therm_o),
    .bin_q_o   (bin_o)
  );

  seg_dac_level #(.SEG_W(SEG_W), .BIN_W(BIN_W), .THERM_W(THERM_W)) i_level (
    .therm_i (therm_o),
    .bin_i   (bin_o),
    .level_o (level_o)
  );

  assert_therm_contig_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((therm_o & (therm_o + 1'b1)) == '0));

  assert_bin_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (bin_o == $past(eff_code[BIN_W-1:0])));

  assert_therm_latency_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($countones(therm_o) == int'($past(eff_code[DATA_W-1:BIN_W]))));

  assert_level_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (level_o == $past(invert_i ? ~data_i : data_i)));
endmodule

// File: tb/test_seg_dac_front.sv
`timescale 1ns/1ps
module test_seg_dac_front;
  typedef struct {
    logic [14:0] therm;
    logic [5:0]  bin;
    logic [9:0]  level;
    int          due;
    int          tog;
    string       req;
  } item_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [9:0]  data_i = '0;
  logic        invert_i = 1'b0;
  logic [14:0] therm_o;
  logic [5:0]  bin_o;
  logic [9:0]  level_o;

  int    n_chk = 0;
  int    n_fail = 0;
  int    cyc = 0;
  item_t sb_q[$];
  logic [20:0] last_exp = '0;
  logic [20:0] prev_out = '0;

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  seg_dac_front i_seg_dac_front (
    .clk_i (clk_i), .rst_ni (rst_ni), .data_i (data_i), .invert_i (invert_i),
    .therm_o (therm_o), .bin_o (bin_o), .level_o (level_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // driver: apply a word on the falling edge, push what the next edge must show
  task automatic drive(input logic [9:0] code, input logic inv, input string req, input bit chk_tog = 1'b0);
    item_t it;
    logic [9:0] eff;
    logic [20:0] vec;
    @(negedge clk_i);
    data_i   = code;
    invert_i = inv;
    eff      = inv ? ~code : code;
    it.therm = 15'((32'd1 << eff[9:6]) - 1);
    it.bin   = eff[5:0];
    it.level = eff;
    it.due   = cyc + 1;
    it.req   = req;
    vec      = {it.therm, it.bin};
    it.tog   = chk_tog ? $countones(vec ^ last_exp) : -1;
    last_exp = vec;
    sb_q.push_back(it);
  endtask

  // monitor
  always @(negedge clk_i) begin
    while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
      item_t it;
      it = sb_q.pop_front();
      chk(therm_o == it.therm, it.req, "therm_o", int'(therm_o), int'(it.therm));
      chk(bin_o == it.bin, "R4", "bin_o", int'(bin_o), int'(it.bin));
      chk(level_o == it.level, "R7", "level_o", int'(level_o), int'(it.level));
      chk((therm_o & (therm_o + 15'd1)) == '0, "R3", "therm contiguity", int'(therm_o), int'(it.therm));
      if (it.tog >= 0)
        chk($countones({therm_o, bin_o} ^ prev_out) == it.tog, "R9", "toggle count",
            $countones({therm_o, bin_o} ^ prev_out), it.tog);
    end
    prev_out = {therm_o, bin_o};
  end

  task automatic flush();
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    #(4 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    chk(therm_o == '0 && bin_o == '0 && level_o == '0, "R6", "reset state",
        int'(level_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 R3 R5 R7: full sweep, no inversion
    for (int c = 0; c < 1024; c++) drive(10'(c), 1'b0, "R5");
    // R2: full sweep, inverted
    for (int c = 0; c < 1024; c++) drive(10'(c), 1'b1, "R2");
    // R2 R5: polarity toggled every cycle
    for (int c = 0; c < 64; c++) drive(10'(c * 13 + 5), c[0], "R2");
    flush();

    // R8 end points and mid-scale
    drive(10'd0,    1'b0, "R8");
    drive(10'd512,  1'b0, "R8");
    drive(10'd1023, 1'b0, "R8");
    drive(10'd0,    1'b1, "R8");
    drive(10'd512,  1'b1, "R8");
    drive(10'd1023, 1'b1, "R8");

    // R9 switching events
    drive(10'h01F, 1'b0, "R9");
    drive(10'h3E0, 1'b0, "R9", 1'b1);
    drive(10'h1FF, 1'b0, "R9");
    drive(10'h200, 1'b0, "R9", 1'b1);
    flush();

    // R6 reset mid-run: clears at once, ignores data while held
    drive(10'h2AB, 1'b0, "R1");
    flush();
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(therm_o == '0 && bin_o == '0 && level_o == '0, "R6", "async clear",
        int'(level_o), 0);
    data_i = 10'h3FF;
    invert_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(level_o == '0, "R6", "data ignored in reset", int'(level_o), 0);
    chk(therm_o == '0, "R6", "therm held off in reset", int'(therm_o), 0);
    rst_ni = 1'b1;
    last_exp = '0;
    drive(10'h155, 1'b1, "R5");
    flush();

    summary();
    $finish;
  end
endmodule